// File: doc/BRIEF.md
# Level-Sensitive Platform Interrupt Controller

This block collects a vector of level-sensitive interrupt lines and presents a single external interrupt request to one processor. Each source carries a latched pending flag, an enable, a 3-bit priority and an in-service (claimed) flag. The request output is raised whenever some source that is both pending and enabled has a priority strictly above a 2-bit threshold. Source number 0 is reserved and never requests.

Software services interrupts through a claim/complete word. A read of that word returns the winning source number and, in the same access, moves the source from pending to in-service. A write of a source number ends its service. While a source is in service, a new assertion of its line is held in a shadow flag instead of the pending flag; when the source is completed with its shadow set, the pending flag is raised again at once, so an assertion that arrived during service is not lost.

Access is through a plain 32-bit word bus with a 10-bit byte address, separate read and write strobes and registered read data that is valid on the cycle after the read strobe. The low two address bits are ignored. The number of sources is a parameter from 1 to 180.

Top module: `lvl_intc`

## Requirements
- R1: After reset the pending, in-service and shadow flags, all priorities, all enables and the threshold are zero, irq_o is low and a claim read returns 0.
- R2: The priority of source k is the word at byte offset 0x030 + 4*(k-1); a write stores only data bits [2:0] and reads return them zero-extended.
- R3: The threshold is the word at offset 0x318; a write stores only data bits [1:0].
- R4: The enable bitmap starts at offset 0x300, bit k of word w enabling source 32*w+k; the bit for source 0 always reads 0.
- R5: The pending bitmap starts at offset 0x000 with the same bit layout as the enables; it is read-only and writes to it leave it unchanged.
- R6: A source sampled high at a clock edge while not in service has its pending flag set at that edge; the flag stays set after the line drops until the source is claimed.
- R7: irq_o is high exactly when some pending, enabled source has a priority strictly greater than the threshold.
- R8: A read of offset 0x31C returns the qualifying source with the highest priority, ties going to the lowest number, or 0 when none qualifies; the returned source's pending flag is cleared and it enters service at that edge.
- R9: While a source is in service a high line sets its shadow flag and not its pending flag; a low line clears the shadow flag.
- R10: A write of n to offset 0x31C ends service of source n when it is in service, and sets its pending flag at that same edge when its shadow flag is set; for a source not in service the write has no effect.
- R11: The source-mode region (0x018 to 0x02F) and every offset outside the regions above read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level interrupt lines, bit k is source k |
| addr_i | input | 10 | Byte address of the access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_i |
| irq_o | output | 1 | External interrupt request |

## Verification
Register storage is swept over every priority word with data carrying junk in the upper bits and over all eight threshold codes, which separates correct masking from full-width storage. The request output is tried against every priority and threshold pair for one source, telling a strict comparison from a non-strict one. A scattered pending pattern with repeating priorities is drained by successive claims against an arithmetic model, which distinguishes highest-priority selection, lowest-number tie breaking and the clearing of each claimed flag. Lines held high or dropped across service, and completions of sources not in service, tell the shadow re-raise apart from plain level re-sampling by looking at irq_o on the very edge of completion.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int unsigned ADDR_W = 10;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned PRIO_W = 3;
    localparam int unsigned THR_W  = 2;

    // word indices of the register regions
    localparam int unsigned W_PEND  = 0;
    localparam int unsigned W_MODE  = 6;
    localparam int unsigned W_PRIO  = 12;
    localparam int unsigned W_EN    = 192;
    localparam int unsigned W_THR   = 198;
    localparam int unsigned W_CLAIM = 199;
    localparam int unsigned MAP_BM_WORDS = 6;
    localparam int unsigned MAX_SRC = W_EN - W_PRIO;

    localparam logic [ADDR_W-1:0] OFS_CLAIM = ADDR_W'(W_CLAIM * 4);

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PEND,
        RG_MODE,
        RG_PRIO,
        RG_EN,
        RG_THR,
        RG_CLAIM
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [7:0] index;
    } dec_t;

    function automatic dec_t decode(logic [ADDR_W-1:0] a, int unsigned nsrc,
                                    int unsigned nwords);
        dec_t d;
        int unsigned wi;
        wi = int'(a) >> 2;
        d.region = RG_NONE;
        d.index  = '0;
        if (wi < nwords) begin
            d.region = RG_PEND;
            d.index  = 8'(wi - W_PEND);
        end else if (wi >= W_MODE && wi < W_PRIO) begin
            d.region = RG_MODE;
        end else if (wi >= W_PRIO && wi < W_PRIO + nsrc) begin
            d.region = RG_PRIO;
            d.index  = 8'(wi - W_PRIO);
        end else if (wi >= W_EN && wi < W_EN + nwords) begin
            d.region = RG_EN;
            d.index  = 8'(wi - W_EN);
        end else if (wi == W_THR) begin
            d.region = RG_THR;
        end else if (wi == W_CLAIM) begin
            d.region = RG_CLAIM;
        end
        return d;
    endfunction

endpackage

// File: rtl/intc_src_cell.sv
module intc_src_cell (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    input  logic take_i,
    input  logic done_i,
    output logic pend_o,
    output logic busy_o,
    output logic shadow_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_o   <= 1'b0;
            busy_o   <= 1'b0;
            shadow_o <= 1'b0;
        end else begin
            shadow_o <= level_i & (shadow_o | busy_o);
            if (take_i) begin
                busy_o <= 1'b1;
                pend_o <= 1'b0;
            end else if (done_i && busy_o) begin
                busy_o <= 1'b0;
                pend_o <= pend_o | shadow_o;
            end else if (level_i && !busy_o) begin
                pend_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/intc_cfg.sv
module intc_cfg
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 31
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_i,
    input  dec_t                             dec_i,
    input  logic [DATA_W-1:0]                wdata_i,
    output logic [NUM_SRC:0][PRIO_W-1:0]     prio_o,
    output logic [NUM_SRC:0]                 en_o,
    output logic [THR_W-1:0]                 thr_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_o <= '0;
            en_o   <= '0;
            thr_o  <= '0;
        end else if (wr_i) begin
            for (int k = 1; k <= int'(NUM_SRC); k++) begin
                if (dec_i.region == RG_PRIO && dec_i.index == 8'(k - 1))
                    prio_o[k] <= wdata_i[PRIO_W-1:0];
                if (dec_i.region == RG_EN && dec_i.index == 8'(k / 32))
                    en_o[k] <= wdata_i[k % 32];
            end
            if (dec_i.region == RG_THR)
                thr_o <= wdata_i[THR_W-1:0];
        end
    end

endmodule

// File: rtl/intc_arb.sv
module intc_arb
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 31,
    parameter int unsigned IDW     = 5
) (
    input  logic [NUM_SRC:0]             pend_i,
    input  logic [NUM_SRC:0]             en_i,
    input  logic [NUM_SRC:0][PRIO_W-1:0] prio_i,
    input  logic [THR_W-1:0]             thr_i,
    output logic [IDW-1:0]               win_id_o,
    output logic                         win_valid_o
);

    logic [PRIO_W-1:0] best_p;

    // strict comparison keeps the lowest number among equal priorities
    always_comb begin
        win_id_o = '0;
        best_p   = PRIO_W'(thr_i);
        for (int k = 1; k <= int'(NUM_SRC); k++) begin
            if (pend_i[k] && en_i[k] && prio_i[k] > best_p) begin
                win_id_o = IDW'(k);
                best_p   = prio_i[k];
            end
        end
        win_valid_o = (win_id_o != '0);
    end

endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 31
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC:1]     src_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 rd_i,
    input  logic                 wr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 irq_o
);

    localparam int unsigned NWORDS = (NUM_SRC + 32) / 32;
    localparam int unsigned IDW    = $clog2(NUM_SRC + 1);
    localparam int unsigned BMW    = NWORDS * 32;

    initial begin
        if (NUM_SRC < 1 || NUM_SRC > MAX_SRC || NWORDS > MAP_BM_WORDS)
            $error("lvl_intc: NUM_SRC out of range");
    end

    dec_t                         dec;
    logic [NUM_SRC:0]             pend_v;
    logic [NUM_SRC:0]             busy_v;
    logic [NUM_SRC:0]             shadow_v;
    logic [NUM_SRC:0]             en_v;
    logic [NUM_SRC:0][PRIO_W-1:0] prio_v;
    logic [THR_W-1:0]             thr_v;
    logic [IDW-1:0]               win_id;
    logic                         win_valid;
    logic                         claim_rd;
    logic                         cmpl_wr;
    logic [BMW-1:0]               pend_pad;
    logic [BMW-1:0]               en_pad;
    logic [DATA_W-1:0]            rd_val;

    assign dec      = decode(addr_i, NUM_SRC, NWORDS);
    assign claim_rd = rd_i && dec.region == RG_CLAIM;
    assign cmpl_wr  = wr_i && !rd_i && dec.region == RG_CLAIM;

    intc_cfg #(.NUM_SRC(NUM_SRC)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr_i && !rd_i),
        .dec_i   (dec),
        .wdata_i (wdata_i),
        .prio_o  (prio_v),
        .en_o    (en_v),
        .thr_o   (thr_v)
    );

    assign pend_v[0]   = 1'b0;
    assign busy_v[0]   = 1'b0;
    assign shadow_v[0] = 1'b0;

    for (genvar k = 1; k <= NUM_SRC; k++) begin : g_src
        intc_src_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .level_i  (src_i[k]),
            .take_i   (claim_rd && win_valid && win_id == IDW'(k)),
            .done_i   (cmpl_wr && wdata_i == DATA_W'(k)),
            .pend_o   (pend_v[k]),
            .busy_o   (busy_v[k]),
            .shadow_o (shadow_v[k])
        );
    end

    intc_arb #(.NUM_SRC(NUM_SRC), .IDW(IDW)) u_arb (
        .pend_i      (pend_v),
        .en_i        (en_v),
        .prio_i      (prio_v),
        .thr_i       (thr_v),
        .win_id_o    (win_id),
        .win_valid_o (win_valid)
    );

    assign irq_o    = win_valid;
    assign pend_pad = BMW'(pend_v);
    assign en_pad   = {en_v[NUM_SRC:1], 1'b0} | BMW'(0);

    always_comb begin
        rd_val = '0;
        unique case (dec.region)
            RG_PEND:  rd_val = DATA_W'(pend_pad >> (32 * int'(dec.index)));
            RG_EN:    rd_val = DATA_W'(en_pad >> (32 * int'(dec.index)));
            RG_PRIO:  rd_val = DATA_W'(prio_v[int'(dec.index) + 1]);
            RG_THR:   rd_val = DATA_W'(thr_v);
            RG_CLAIM: rd_val = DATA_W'(win_id);
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_o <= '0;
        else if (rd_i)
            rdata_o <= rd_val;
    end

endmodule

// File: rtl/intc_chk.sv
module intc_chk
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 31
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_SRC:1]  src_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              rd_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              irq_o,
    input logic [NUM_SRC:0]  pend_v,
    input logic [NUM_SRC:0]  en_v,
    input logic [NUM_SRC:0]  busy_v,
    input logic [NUM_SRC:0]  shadow_v
);

    AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (pend_v & en_v) != '0); // R7

    AST_EMPTY_CLAIM_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_i && addr_i == OFS_CLAIM && !irq_o) |=> rdata_o == '0); // R8

    AST_CLAIM_RETURNS_ID: assert property (@(posedge clk) disable iff (rst)
        (rd_i && addr_i == OFS_CLAIM && irq_o) |=> rdata_o != '0); // R8

    AST_BUSY_NOT_PENDING: assert property (@(posedge clk) disable iff (rst)
        (busy_v & pend_v) == '0); // R9

    for (genvar k = 1; k <= NUM_SRC; k++) begin : g_shadow
        AST_SHADOW_DROPS: assert property (@(posedge clk) disable iff (rst)
            !$past(src_i[k]) |-> !shadow_v[k]); // R9
    end

endmodule

bind lvl_intc intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .src_i    (src_i),
    .addr_i   (addr_i),
    .rd_i     (rd_i),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o),
    .pend_v   (pend_v),
    .en_v     (en_v),
    .busy_v   (busy_v),
    .shadow_v (shadow_v)
);

// File: tb/tb_lvl_intc.sv
module tb_lvl_intc;

    localparam int N = 31;
    localparam logic [9:0] A_PEND  = 10'h000;
    localparam logic [9:0] A_MODE  = 10'h018;
    localparam logic [9:0] A_PRIO  = 10'h030;
    localparam logic [9:0] A_EN    = 10'h300;
    localparam logic [9:0] A_THR   = 10'h318;
    localparam logic [9:0] A_CLAIM = 10'h31C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N:1]  src = '0;
    logic [9:0]  addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int pr [32];
    bit [31:0] pm;
    bit [31:0] cm;
    logic [31:0] v;

    always #5 clk = ~clk;

    lvl_intc #(.NUM_SRC(N)) dut (
        .clk(clk), .rst(rst), .src_i(src), .addr_i(addr), .rd_i(rd),
        .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    function automatic int best_of(bit [31:0] m, int thr);
        int b = 0;
        int bp = thr;
        for (int k = 1; k <= N; k++)
            if (m[k] && pr[k] > bp) begin b = k; bp = pr[k]; end
        return b;
    endfunction

    // claim until nothing qualifies, comparing with the model
    task automatic drain();
        for (int i = 0; i < 33; i++) begin
            int e;
            e = best_of(pm, 0);
            check("R7 irq before claim", 32'(irq), 32'(e != 0));
            bus_rd(A_CLAIM, v);
            check("R8 claim winner", v, 32'(e));
            if (e == 0) break;
            pm[e] = 1'b0;
            cm[e] = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq", 32'(irq), 32'd0);
        bus_rd(A_PEND, v);  check("R1 pending", v, 32'd0);
        bus_rd(A_THR, v);   check("R1 threshold", v, 32'd0);
        bus_rd(A_EN, v);    check("R1 enable", v, 32'd0);
        bus_rd(A_PRIO, v);  check("R1 priority", v, 32'd0);
        bus_rd(A_CLAIM, v); check("R1 claim", v, 32'd0);

        // R2 priority sweep
        for (int k = 1; k <= N; k++) begin
            bus_wr(A_PRIO + 10'(4 * (k - 1)), 32'(k * 37 + 32'hFFF0));
            pr[k] = (k * 37) & 7;
        end
        for (int k = 1; k <= N; k++) begin
            bus_rd(A_PRIO + 10'(4 * (k - 1)), v);
            check("R2 priority readback", v, 32'(pr[k]));
        end

        // R3 threshold masking
        for (int t = 0; t < 8; t++) begin
            bus_wr(A_THR, 32'hFFFF_FFF8 | 32'(t));
            bus_rd(A_THR, v);
            check("R3 threshold readback", v, 32'(t & 3));
        end
        bus_wr(A_THR, 32'd0);

        // R4 enable bitmap
        bus_wr(A_EN, 32'h0000_0F0F);
        bus_rd(A_EN, v); check("R4 enable partial", v, 32'h0000_0F0E);
        bus_wr(A_EN, 32'hFFFF_FFFF);
        bus_rd(A_EN, v); check("R4 enable all, bit0 zero", v, 32'hFFFF_FFFE);

        // R5 R6 latch a scattered pattern, then drop the lines
        @(negedge clk);
        src = 31'h2D5A_C3E7;
        @(negedge clk);
        src = '0;
        @(negedge clk);
        pm = {31'h2D5A_C3E7, 1'b0};
        cm = '0;
        bus_rd(A_PEND, v); check("R6 pending latched after drop", v, pm);
        bus_wr(A_PEND, 32'd0);
        bus_wr(A_PEND, 32'hFFFF_FFFF);
        bus_rd(A_PEND, v); check("R5 pending read-only", v, pm);

        // R8 drain, then lift zero-priority leftovers to 1 and drain again
        drain();
        for (int k = 1; k <= N; k++)
            if (pm[k]) begin
                pr[k] = 1;
                bus_wr(A_PRIO + 10'(4 * (k - 1)), 32'd1);
            end
        drain();
        check("R8 model empty", pm, 32'd0);
        bus_rd(A_PEND, v); check("R8 claims cleared pending", v, 32'd0);
        for (int k = 1; k <= N; k++)
            if (cm[k]) bus_wr(A_CLAIM, 32'(k));
        bus_rd(A_PEND, v); check("R10 complete with low line", v, 32'd0);

        // R7 exhaustive priority/threshold for source 5 only
        bus_wr(A_EN, 32'h0000_0020);
        @(negedge clk); src[5] = 1'b1;
        @(negedge clk); src[5] = 1'b0;
        for (int t = 0; t < 4; t++)
            for (int p = 0; p < 8; p++) begin
                bus_wr(A_PRIO + 10'h010, 32'(p));
                bus_wr(A_THR, 32'(t));
                check("R7 strict compare", 32'(irq), 32'(p > t));
            end
        bus_wr(A_PRIO + 10'h010, 32'd7);
        bus_wr(A_THR, 32'd0);
        pr[5] = 7;
        bus_wr(A_EN, 32'd0);
        check("R7 disabled source", 32'(irq), 32'd0);
        bus_wr(A_EN, 32'hFFFF_FFFF);
        bus_rd(A_CLAIM, v); check("R8 claim source 5", v, 32'd5);
        bus_wr(A_CLAIM, 32'd5);

        // R9 R10 shadow with line held high on source 9
        @(negedge clk); src[9] = 1'b1;
        @(negedge clk);
        bus_rd(A_CLAIM, v); check("R8 claim source 9", v, 32'd9);
        repeat (3) @(negedge clk);
        bus_rd(A_PEND, v); check("R9 no pending while in service", v, 32'd0);
        check("R9 irq low while in service", 32'(irq), 32'd0);
        bus_wr(A_CLAIM, 32'd9);
        check("R10 shadow re-raise on completion edge", 32'(irq), 32'd1);
        bus_rd(A_CLAIM, v); check("R10 reclaim source 9", v, 32'd9);
        src[9] = 1'b0;
        repeat (2) @(negedge clk);
        bus_wr(A_CLAIM, 32'd9);
        check("R9 dropped line clears shadow", 32'(irq), 32'd0);
        bus_rd(A_PEND, v); check("R9 pending after drop", v, 32'd0);

        // R10 completion of a source not in service
        @(negedge clk); src[10] = 1'b1;
        @(negedge clk); src[10] = 1'b0;
        bus_rd(A_PEND, v); check("R6 pending source 10", v, 32'h0000_0400);
        bus_wr(A_CLAIM, 32'd10);
        bus_rd(A_PEND, v); check("R10 unserviced complete ignored", v, 32'h0000_0400);
        bus_rd(A_CLAIM, v); check("R8 claim source 10", v, 32'd10);
        bus_wr(A_CLAIM, 32'd10);

        // R11 mode region and unmapped offsets
        bus_wr(A_MODE, 32'hFFFF_FFFF);
        bus_rd(A_MODE, v);  check("R11 mode region", v, 32'd0);
        bus_rd(10'h0B0, v); check("R11 past priorities", v, 32'd0);
        bus_wr(10'h3F0, 32'hFFFF_FFFF);
        bus_rd(10'h3F0, v); check("R11 unmapped", v, 32'd0);
        bus_rd(10'h304, v); check("R11 past enables", v, 32'd0);
        bus_rd(10'h004, v); check("R11 past pending", v, 32'd0);
        bus_rd(A_THR, v);   check("R11 threshold untouched", v, 32'd0);
        bus_rd(A_EN, v);    check("R11 enable untouched", v, 32'hFFFF_FFFE);
        check("R11 irq untouched", 32'(irq), 32'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule